// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache that sits between a processor's load/store port and a word-wide memory port. Each line holds a tag and a valid bit and sits at a fixed place in the array. Its position is the block address modulo the line count, so the index is taken from low-order address bits. A read that hits returns its word in the same cycle. A read that misses holds the processor stalled while the whole line is fetched, one word at a time, and then completes as a hit.

Every store is written through to memory by way of a small FIFO of posted writes. A store stalls only when that FIFO is full. A configuration input chooses what happens on a store miss. In allocate mode the line is fetched first and then updated. In write-around mode the store only goes to memory. Before any line fetch starts, the FIFO is drained completely, so a fetch never returns data older than a pending store.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid, so the first read to any address fetches its line. With no request pending, stall_o and mem_req_o are 0.
- R2: A byte address splits from the low end into the byte-in-line offset, the index and the tag. The offset has log2(LINE_WORDS*DATA_W/8) bits, the index has log2(LINE_CNT) bits, and the tag is the rest. With the defaults (32-bit address, 64 lines of four 32-bit words) this gives 4, 6 and 22 bits. Byte 1200 then sits in line 11: it shares that line with byte 1204 and evicts byte 176.
- R3: A read hit needs a valid line whose stored tag equals the address tag. It returns the word with stall_o low and issues no memory read.
- R4: A read miss raises stall_o and reads the LINE_WORDS words of the line from memory, lowest address first. It replaces whatever the line held and then returns the requested word. mem_req_o, mem_we_o and mem_addr_o stay constant until mem_ack_i.
- R5: Line hits and misses follow the direct-mapped rule. Take word addresses 22, 26, 22, 26, 16, 3, 16, 18, each placed at index (w mod 8) with tag (w div 8). They give miss, miss, hit, hit, miss, miss, hit, miss. The last access replaces index 2, so a following read of 26 misses.
- R6: A store that hits updates the cached word. It also sends exactly one word write to memory.
- R7: The posted-write FIFO holds WB_DEPTH (default 4) entries. A store is accepted without stall while the FIFO has room and is held with stall_o high only while it is full.
- R8: With cfg_alloc_i = 0, a store miss fetches nothing and leaves the cache contents unchanged. The store goes to memory only.
- R9: With cfg_alloc_i = 1, a store miss first fetches the line. The stored word then becomes readable as a hit.
- R10: A line fetch starts only when the posted-write FIFO is empty. A read after a write-around store to the same address therefore returns the stored data.
- R11: Posted writes reach memory in the order they were accepted. The last of two stores to one address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_alloc_i | input | 1 | Store-miss policy: 1 allocate, 0 write-around |
| req_i | input | 1 | Processor request; held with its fields while stall_o is 1 |
| we_i | input | 1 | 1 store, 0 load |
| addr_i | input | ADDR_W | Byte address (word aligned) |
| wdata_i | input | DATA_W | Store data |
| rdata_o | output | DATA_W | Load data, valid when req_i and not stall_o |
| stall_o | output | 1 | Request not completing this cycle |
| mem_req_o | output | 1 | Memory transaction pending |
| mem_we_o | output | 1 | Memory transaction is a write |
| mem_addr_o | output | ADDR_W | Memory word byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | One-cycle completion of the pending transaction |
| mem_rdata_i | input | DATA_W | Memory read data, valid with mem_ack_i |

## Verification
A corrupted valid bit or tag shows up on the very next access to that index. It appears as an extra or a missing burst of memory reads, or as a load word that differs from the last value stored. A fault in the FIFO pointers or count shows either as a store stalled with room left or as a lost or reordered write. The memory contents expose this a few cycles later, once the FIFO has drained. If a fetch is launched ahead of pending stores, a read after a write-around store returns the old word within the same access.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_DRAIN = 2'd1,
    MS_FILL  = 2'd2
  } mem_state_e;
endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int DATA_W     = 32,
  parameter int LINE_CNT   = 64,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = 6,
  parameter int WORD_W     = 2,
  parameter int TAG_W      = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WORD_W-1:0] rd_word_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inval_i,
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  line_idx_i,
  input  logic [TAG_W-1:0]  commit_tag_i
);
  localparam int ENTRIES = LINE_CNT * LINE_WORDS;

  logic [LINE_CNT-1:0] valid_q;
  logic [TAG_W-1:0]    tag_q  [LINE_CNT];
  logic [DATA_W-1:0]   data_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (inval_i)  valid_q[line_idx_i] <= 1'b0;
      if (commit_i) valid_q[line_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit_i) tag_q[line_idx_i] <= commit_tag_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[{wr_idx_i, wr_word_i}] <= wr_data_i;
  end

  assign hit_o     = valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_data_o = data_q[{rd_idx_i, rd_word_i}];
endmodule

// File: rtl/wt_write_buffer.sv
module wt_write_buffer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= push_addr_i;
      data_q[wr_ptr_q] <= push_data_i;
    end
  end

  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/wt_mem_seq.sv
module wt_mem_seq
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int WORD_W = 2,
  parameter int TAG_W  = 22,
  parameter int BYTE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_need_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              wb_empty_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic              wb_pop_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              fill_wr_o,
  output logic [WORD_W-1:0] fill_word_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic              inval_o,
  output logic              commit_o,
  output logic [IDX_W-1:0]  line_idx_o,
  output logic [TAG_W-1:0]  commit_tag_o
);
  mem_state_e        state_q;
  logic [WORD_W-1:0] cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;
  logic              start_fill;

  // stores always go first: a fetch never overtakes a posted write
  assign start_fill = (state_q == MS_IDLE) && wb_empty_i && fill_need_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      tag_q   <= '0;
    end else begin
      unique case (state_q)
        MS_IDLE: begin
          if (!wb_empty_i) begin
            state_q <= MS_DRAIN;
          end else if (fill_need_i) begin
            state_q <= MS_FILL;
            cnt_q   <= '0;
            idx_q   <= fill_idx_i;
            tag_q   <= fill_tag_i;
          end
        end
        MS_DRAIN: if (mem_ack_i) state_q <= MS_IDLE;
        MS_FILL: begin
          if (mem_ack_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '1) state_q <= MS_IDLE;
          end
        end
        default: state_q <= MS_IDLE;
      endcase
    end
  end

  assign mem_req_o    = (state_q != MS_IDLE);
  assign mem_we_o     = (state_q == MS_DRAIN);
  assign mem_addr_o   = (state_q == MS_DRAIN) ? wb_addr_i
                                              : {tag_q, idx_q, cnt_q, {BYTE_W{1'b0}}};
  assign mem_wdata_o  = wb_data_i;
  assign wb_pop_o     = (state_q == MS_DRAIN) && mem_ack_i;
  assign fill_wr_o    = (state_q == MS_FILL) && mem_ack_i;
  assign fill_word_o  = cnt_q;
  assign fill_data_o  = mem_rdata_i;
  assign inval_o      = start_fill;
  assign commit_o     = fill_wr_o && (cnt_q == '1);
  assign line_idx_o   = start_fill ? fill_idx_i : idx_q;
  assign commit_tag_o = tag_q;
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_CNT   = 64,
  parameter int LINE_WORDS = 4,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_alloc_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(LINE_CNT);
  localparam int OFF_W  = BYTE_W + WORD_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx;
  logic [WORD_W-1:0] cpu_word;

  assign cpu_tag  = addr_i[ADDR_W-1 -: TAG_W];
  assign cpu_idx  = addr_i[OFF_W +: IDX_W];
  assign cpu_word = addr_i[BYTE_W +: WORD_W];

  logic              line_hit;
  logic              wb_empty, wb_full, wb_push, wb_pop;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic              fill_need, fill_wr, inval, commit;
  logic [WORD_W-1:0] fill_word;
  logic [DATA_W-1:0] fill_data;
  logic [IDX_W-1:0]  line_idx;
  logic [TAG_W-1:0]  commit_tag;
  logic              st_wr_en;
  logic [IDX_W-1:0]  st_wr_idx;
  logic [WORD_W-1:0] st_wr_word;
  logic [DATA_W-1:0] st_wr_data;

  assign fill_need = req_i && !line_hit && (!we_i || cfg_alloc_i);
  assign stall_o   = req_i && (we_i ? (wb_full || (!line_hit && cfg_alloc_i))
                                    : !line_hit);
  assign wb_push   = req_i && we_i && !stall_o;

  assign st_wr_en   = fill_wr || (wb_push && line_hit);
  assign st_wr_idx  = fill_wr ? line_idx  : cpu_idx;
  assign st_wr_word = fill_wr ? fill_word : cpu_word;
  assign st_wr_data = fill_wr ? fill_data : wdata_i;

  wt_line_store #(
    .DATA_W(DATA_W), .LINE_CNT(LINE_CNT), .LINE_WORDS(LINE_WORDS),
    .IDX_W(IDX_W), .WORD_W(WORD_W), .TAG_W(TAG_W)
  ) store_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_idx_i     (cpu_idx),
    .rd_word_i    (cpu_word),
    .rd_tag_i     (cpu_tag),
    .hit_o        (line_hit),
    .rd_data_o    (rdata_o),
    .wr_en_i      (st_wr_en),
    .wr_idx_i     (st_wr_idx),
    .wr_word_i    (st_wr_word),
    .wr_data_i    (st_wr_data),
    .inval_i      (inval),
    .commit_i     (commit),
    .line_idx_i   (line_idx),
    .commit_tag_i (commit_tag)
  );

  wt_write_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)
  ) wbuf_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wb_push),
    .push_addr_i (addr_i),
    .push_data_i (wdata_i),
    .pop_i       (wb_pop),
    .head_addr_o (wb_addr),
    .head_data_o (wb_data),
    .empty_o     (wb_empty),
    .full_o      (wb_full)
  );

  wt_mem_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .WORD_W(WORD_W), .TAG_W(TAG_W), .BYTE_W(BYTE_W)
  ) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_need_i  (fill_need),
    .fill_idx_i   (cpu_idx),
    .fill_tag_i   (cpu_tag),
    .wb_empty_i   (wb_empty),
    .wb_addr_i    (wb_addr),
    .wb_data_i    (wb_data),
    .wb_pop_o     (wb_pop),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .fill_wr_o    (fill_wr),
    .fill_word_o  (fill_word),
    .fill_data_o  (fill_data),
    .inval_o      (inval),
    .commit_o     (commit),
    .line_idx_o   (line_idx),
    .commit_tag_o (commit_tag)
  );
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_alloc_i,
  input logic              req_i,
  input logic              we_i,
  input logic              stall_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              line_hit,
  input logic              wb_empty,
  input logic              wb_full,
  input logic              wb_push
);
  p_read_hit_no_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && line_hit) |-> !stall_o);

  p_hold_until_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_write_no_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && line_hit && !wb_full) |-> !stall_o);

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_push |-> !wb_full);

  p_around_no_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !cfg_alloc_i) |-> !(mem_req_o && !mem_we_o));

  p_fetch_after_drain_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> wb_empty);
endmodule

bind wt_dcache wt_dcache_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/wt_dcache_tb_top.sv
`timescale 1ns/1ps
module wt_dcache_tb_top;
  localparam int CLK_NS = 20;
  localparam int LAT    = 2;
  localparam int MWORDS = 4096;
  localparam int NVEC   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_alloc = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        stall;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #(CLK_NS/2) clk = ~clk;

  wt_dcache dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_alloc_i(cfg_alloc),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .stall_o(stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  // memory model
  logic [31:0] mem [MWORDS];
  logic [31:0] shadow [MWORDS];
  int          wait_q = 0;
  int          reads_n = 0, writes_n = 0;

  function automatic logic [31:0] init_val(int i);
    return 32'hC0DE_0000 ^ (i * 4);
  endfunction

  initial begin
    for (int i = 0; i < MWORDS; i++) begin
      mem[i] = init_val(i);
      shadow[i] = init_val(i);
    end
    mem_ack = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_q == LAT) begin
        mem_ack <= 1'b1;
        wait_q  <= 0;
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          writes_n <= writes_n + 1;
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
          reads_n <= reads_n + 1;
        end
      end else begin
        wait_q <= wait_q + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one processor access; returns load data and stall cycle count
  task automatic cpu_op(input bit w, input bit alloc, input logic [31:0] a,
                        input logic [31:0] d, output logic [31:0] rd, output int stalls);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; cfg_alloc = alloc;
    stalls = 0;
    #1;
    while (stall && stalls < 1000) begin
      @(negedge clk); #1;
      stalls++;
    end
    rd = rdata;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
    if (w) shadow[a[13:2]] = d;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {we, alloc, addr, wdata, expect_fetch}
  localparam logic [66:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 32'h0000_0860, 32'h0, 1'b1},   // R5 w22 miss (R1 cold)
    {1'b0, 1'b0, 32'h0000_0C20, 32'h0, 1'b1},   // R5 w26 miss
    {1'b0, 1'b0, 32'h0000_0860, 32'h0, 1'b0},   // R5 w22 hit
    {1'b0, 1'b0, 32'h0000_0C20, 32'h0, 1'b0},   // R5 w26 hit
    {1'b0, 1'b0, 32'h0000_0800, 32'h0, 1'b1},   // R5 w16 miss
    {1'b0, 1'b0, 32'h0000_0030, 32'h0, 1'b1},   // R5 w3 miss
    {1'b0, 1'b0, 32'h0000_0800, 32'h0, 1'b0},   // R5 w16 hit
    {1'b0, 1'b0, 32'h0000_0820, 32'h0, 1'b1},   // R5 w18 miss, replaces idx 2
    {1'b0, 1'b0, 32'h0000_0C20, 32'h0, 1'b1},   // R5 w26 evicted
    {1'b1, 1'b0, 32'h0000_0800, 32'h1111_2222, 1'b0}, // R6 write hit
    {1'b0, 1'b0, 32'h0000_0800, 32'h0, 1'b0},   // R6 updated word hits
    {1'b1, 1'b0, 32'h0000_0404, 32'h3333_4444, 1'b0}, // R8 write-around
    {1'b0, 1'b0, 32'h0000_0404, 32'h0, 1'b1},   // R10 read after posted store
    {1'b1, 1'b1, 32'h0000_0504, 32'h5555_6666, 1'b1}, // R9 allocate
    {1'b0, 1'b0, 32'h0000_0504, 32'h0, 1'b0},   // R9 hit after allocate
    {1'b0, 1'b0, 32'h0000_0508, 32'h0, 1'b0}    // R4 neighbour word filled
  };

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          st, r0, w0, tot;

    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check(stall == 1'b0, "R1 stall idle", {31'd0, stall}, 32'd0);
    check(mem_req == 1'b0, "R1 mem_req idle", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    check(mem_req == 1'b0 && stall == 1'b0, "R1 idle after release", {30'd0, mem_req, stall}, 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      logic [66:0] e;
      e  = VEC[v];
      r0 = reads_n;
      cpu_op(e[66], e[65], e[64:33], e[32:1], rd, st);
      check((reads_n - r0) == (e[0] ? 4 : 0), $sformatf("R5/R3 fetch v%0d", v),
            32'(reads_n - r0), e[0] ? 32'd4 : 32'd0);
      if (!e[66])
        check(rd == shadow[e[46:35]], $sformatf("R4 data v%0d", v), rd, shadow[e[46:35]]);
      else if (!e[65])
        check(st == 0, $sformatf("R7 store stall v%0d", v), 32'(st), 32'd0);
    end

    // R6: written-through value reaches memory
    idle(20);
    check(mem[12'h200] == 32'h1111_2222, "R6 memory copy", mem[12'h200], 32'h1111_2222);

    // R2: byte 1200 in line 11
    r0 = reads_n;
    cpu_op(1'b0, 1'b0, 32'd1200, 32'd0, rd, st);
    check(reads_n - r0 == 4, "R2 1200 miss", 32'(reads_n - r0), 32'd4);
    check(rd == init_val(300), "R2 1200 data", rd, init_val(300));
    r0 = reads_n;
    cpu_op(1'b0, 1'b0, 32'd1204, 32'd0, rd, st);
    check(reads_n == r0 && st == 0, "R2 1204 same line", 32'(st), 32'd0);
    check(rd == init_val(301), "R4 word order", rd, init_val(301));
    r0 = reads_n;
    cpu_op(1'b0, 1'b0, 32'd176, 32'd0, rd, st);
    check(reads_n - r0 == 4, "R2 176 conflicts", 32'(reads_n - r0), 32'd4);
    r0 = reads_n;
    cpu_op(1'b0, 1'b0, 32'd1200, 32'd0, rd, st);
    check(reads_n - r0 == 4, "R2 1200 evicted", 32'(reads_n - r0), 32'd4);

    // R7/R11: burst of posted stores fills the FIFO
    idle(5);
    w0 = writes_n;
    tot = 0;
    cpu_op(1'b1, 1'b0, 32'h600, 32'hAAAA_0001, rd, st);
    check(st == 0, "R7 first store free", 32'(st), 32'd0);
    cpu_op(1'b1, 1'b0, 32'h610, 32'hAAAA_0002, rd, st); tot += st;
    cpu_op(1'b1, 1'b0, 32'h620, 32'hAAAA_0003, rd, st); tot += st;
    cpu_op(1'b1, 1'b0, 32'h600, 32'hAAAA_0004, rd, st); tot += st;
    cpu_op(1'b1, 1'b0, 32'h630, 32'hAAAA_0005, rd, st); tot += st;
    cpu_op(1'b1, 1'b0, 32'h640, 32'hAAAA_0006, rd, st); tot += st;
    cpu_op(1'b1, 1'b0, 32'h650, 32'hAAAA_0007, rd, st); tot += st;
    check(tot > 0, "R7 stall when full", 32'(tot), 32'd1);
    idle(60);
    check(writes_n - w0 == 7, "R11 all writes out", 32'(writes_n - w0), 32'd7);
    check(mem[12'h180] == 32'hAAAA_0004, "R11 last store wins", mem[12'h180], 32'hAAAA_0004);
    cpu_op(1'b0, 1'b0, 32'h600, 32'd0, rd, st);
    check(rd == 32'hAAAA_0004, "R11 read back", rd, 32'hAAAA_0004);
    check(mem[12'h194] == 32'hAAAA_0007, "R11 tail entry", mem[12'h194], 32'hAAAA_0007);

    // R8: write-around leaves a cached line untouched
    cpu_op(1'b0, 1'b0, 32'h0700, 32'd0, rd, st);
    r0 = reads_n;
    cpu_op(1'b1, 1'b0, 32'h0B00, 32'hBEEF_0001, rd, st);
    check(reads_n == r0, "R8 no fetch", 32'(reads_n - r0), 32'd0);
    r0 = reads_n;
    cpu_op(1'b0, 1'b0, 32'h0700, 32'd0, rd, st);
    check(reads_n == r0 && rd == shadow[12'h1C0], "R8 line kept", rd, shadow[12'h1C0]);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule